// File: doc/BRIEF.md
# Unified Shader Thread Arbiter

The block decides, each clock cycle, which waiting shader thread goes next to a shared execution array. The array serves both vertex work and pixel work. Threads of each kind queue in their own pool in the order they were allocated. A thread can issue only after an external strobe marks it ready. Inside a kind, issue follows strict arrival order: a thread that is not ready at the front of its pool blocks the threads behind it, and the other kind may issue in the meantime.

When both kinds have an issuable thread, the block weighs them against each other. It uses the free space left in two downstream buffers, the vertex output buffer and the pixel export buffer, each multiplied by a per-kind weight that software can program. The kind with the larger product issues, and pixel work wins a tie. When only one kind can issue, it issues whatever the weighting says, so the array is never left idle while work is ready. A grant lasts one cycle, carries the thread ID and kind, and removes the thread from its pool at the clock edge that ends that cycle.

Top module: `shader_thread_arbiter`

## Requirements
- R1: Each pool holds up to 8 threads (a 6-bit ID each). A push is accepted when push_valid is high and the pool is not full. The stall output is high exactly when the pool holds 8 threads, and a push made while the pool is full is dropped.
- R2: Within one pool, threads are granted strictly in the order they were pushed.
- R3: A pool may issue only when its oldest thread is ready. A ready thread behind a thread that is not ready is never granted ahead of it, and in that case the other pool may be granted.
- R4: A ready strobe sets the ready flag of the thread in its own pool whose ID matches. A strobe naming an ID that is not present in that pool, including an ID pushed at a later time, changes nothing. A newly pushed thread starts not ready.
- R5: When exactly one pool can issue, that pool is granted regardless of buffer fill levels and weights.
- R6: When both pools can issue, each score is its weight times its free buffer space. Free space is capacity minus fill, saturating at 0, with a capacity of 64 for both buffers. The higher score is granted, and pixel wins a tie.
- R7: After reset both weights are 8. A write with wgt_wr_en replaces both weights, and the new values first affect a decision in the cycle after the write.
- R8: At most one grant is issued per cycle. grant_type is 0 for vertex and 1 for pixel. The granted thread leaves its pool at the clock edge that ends the grant cycle.
- R9: grant_valid is high in every cycle in which either pool can issue.
- R10: After reset both pools are empty, grant_valid is 0 and both stall outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vtx_push_valid | input | 1 | Allocate a vertex thread |
| vtx_push_id | input | 6 | ID of the allocated vertex thread |
| vtx_stall | output | 1 | Vertex pool full |
| pix_push_valid | input | 1 | Allocate a pixel thread |
| pix_push_id | input | 6 | ID of the allocated pixel thread |
| pix_stall | output | 1 | Pixel pool full |
| vtx_rdy_valid | input | 1 | Ready strobe for the vertex pool |
| vtx_rdy_id | input | 6 | Vertex thread ID being marked ready |
| pix_rdy_valid | input | 1 | Ready strobe for the pixel pool |
| pix_rdy_id | input | 6 | Pixel thread ID being marked ready |
| vtx_buf_fill | input | 7 | Current fill of the vertex output buffer |
| pix_buf_fill | input | 7 | Current fill of the pixel export buffer |
| wgt_wr_en | input | 1 | Write both weights |
| wgt_wr_vtx | input | 4 | New vertex weight |
| wgt_wr_pix | input | 4 | New pixel weight |
| grant_valid | output | 1 | A thread is issued this cycle |
| grant_type | output | 1 | Kind of issued thread (0 vertex, 1 pixel) |
| grant_id | output | 6 | ID of the issued thread |

## Verification
Ready flags are set in reverse arrival order on a full pool, so the grant trace can only match arrival order if the front-of-pool block is real. Balance cases with both pools ready use equal scores, a vertex-favoured fill pair, reprogrammed weights and a fill above capacity. These separate the tie rule, the product scoring, the one-cycle weight latency and the free-space saturation. Single-ready cases with an empty buffer score show that fullness never starves a lone ready kind. Strobes aimed at absent IDs, or at the wrong pool, are followed by pushes of those IDs to show the strobes left no trace.

// File: rtl/sta_pkg.sv
// Shared types for the shader thread arbiter.
// Assumes: one bit is enough to tell the two shader kinds apart.
package sta_pkg;
    typedef enum logic {
        SHD_VTX = 1'b0,
        SHD_PIX = 1'b1
    } shd_kind_e;
endpackage

// File: rtl/sta_thread_pool.sv
// In-order thread pool: a circular queue of thread IDs, each with a ready flag.
// Only the oldest entry is offered for issue; a ready strobe marks every
// present entry whose ID matches. Assumes the caller pops only when
// head_ready is high and that IDs inside one pool are unique.
module sta_thread_pool #(
    parameter int DEPTH = 8,
    parameter int ID_W  = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push_valid,
    input  logic [ID_W-1:0] push_id,
    output logic            stall,
    input  logic            rdy_valid,
    input  logic [ID_W-1:0] rdy_id,
    input  logic            pop,
    output logic            head_ready,
    output logic [ID_W-1:0] head_id
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [ID_W-1:0]  slot_id  [DEPTH];
    logic [DEPTH-1:0] slot_vld;
    logic [DEPTH-1:0] slot_rdy;
    logic [PTR_W-1:0] rd_ptr;
    logic [PTR_W-1:0] wr_ptr;
    logic [CNT_W-1:0] count;
    logic             push_acc;

    // Accept a push only while there is room.
    assign stall    = (count == FULL_CNT);
    assign push_acc = push_valid && !stall;

    // Present the oldest entry.
    assign head_ready = slot_vld[rd_ptr] && slot_rdy[rd_ptr];
    assign head_id    = slot_id[rd_ptr];

    // Per-slot storage: fill on push, clear on pop, mark ready on a matching strobe.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_vld[i] <= 1'b0;
                slot_rdy[i] <= 1'b0;
                slot_id[i]  <= '0;
            end else if (push_acc && (wr_ptr == PTR_W'(i))) begin
                slot_vld[i] <= 1'b1;
                slot_rdy[i] <= 1'b0;
                slot_id[i]  <= push_id;
            end else if (pop && (rd_ptr == PTR_W'(i))) begin
                slot_vld[i] <= 1'b0;
                slot_rdy[i] <= 1'b0;
            end else if (rdy_valid && slot_vld[i] && (slot_id[i] == rdy_id)) begin
                slot_rdy[i] <= 1'b1;
            end
        end
    end

    // Advance the write pointer on each accepted push.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wr_ptr <= '0;
        else if (push_acc)
            wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
    end

    // Advance the read pointer on each pop.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_ptr <= '0;
        else if (pop)
            rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
    end

    // Track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (push_acc && !pop)
            count <= count + 1'b1;
        else if (pop && !push_acc)
            count <= count - 1'b1;
    end

    // R1: occupancy never exceeds the pool depth.
    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);

    // R1: the counter agrees with the per-slot valid flags.
    assert_count_matches_slots_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(slot_vld) == int'(count));

    // R1: a push into a full pool with no pop leaves it full and unchanged in size.
    assert_full_push_dropped_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && stall && !pop) |=> (count == FULL_CNT));

    // R3: an entry is removed only when the oldest entry is ready.
    assert_pop_only_ready_head_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> head_ready);
endmodule

// File: rtl/sta_weight_reg.sv
// Holds the two programmable balance weights. Both are written together and
// reset to DEF_WGT. Assumes the writer holds the data stable with wr_en.
module sta_weight_reg #(
    parameter int WGT_W   = 4,
    parameter int DEF_WGT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WGT_W-1:0] wr_vtx,
    input  logic [WGT_W-1:0] wr_pix,
    output logic [WGT_W-1:0] wgt_vtx,
    output logic [WGT_W-1:0] wgt_pix
);
    localparam logic [WGT_W-1:0] DEF_VAL = WGT_W'(DEF_WGT);

    // Load both weights on a write; restore the defaults on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wgt_vtx <= DEF_VAL;
            wgt_pix <= DEF_VAL;
        end else if (wr_en) begin
            wgt_vtx <= wr_vtx;
            wgt_pix <= wr_pix;
        end
    end

    // R7: a write is visible on the next cycle.
    assert_weight_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (wgt_vtx == $past(wr_vtx)) && (wgt_pix == $past(wr_pix)));

    // R7: without a write the weights hold.
    assert_weight_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(wgt_vtx) && $stable(wgt_pix));
endmodule

// File: rtl/sta_balance.sv
// Chooses between vertex and pixel issue. A kind that alone can issue wins
// outright; with both ready, the larger weight * free-space product wins and
// pixel takes ties. Free space saturates at zero when fill exceeds capacity.
module sta_balance #(
    parameter int WGT_W   = 4,
    parameter int FILL_W  = 7,
    parameter int VTX_CAP = 64,
    parameter int PIX_CAP = 64
) (
    input  logic              v_ready,
    input  logic              p_ready,
    input  logic [WGT_W-1:0]  wgt_vtx,
    input  logic [WGT_W-1:0]  wgt_pix,
    input  logic [FILL_W-1:0] fill_vtx,
    input  logic [FILL_W-1:0] fill_pix,
    output logic              issue,
    output sta_pkg::shd_kind_e pick
);
    import sta_pkg::*;

    localparam int SCORE_W = WGT_W + FILL_W;
    localparam logic [FILL_W-1:0] VCAP = FILL_W'(VTX_CAP);
    localparam logic [FILL_W-1:0] PCAP = FILL_W'(PIX_CAP);

    logic [FILL_W-1:0]  free_vtx;
    logic [FILL_W-1:0]  free_pix;
    logic [SCORE_W-1:0] score_vtx;
    logic [SCORE_W-1:0] score_pix;

    // Free space in each downstream buffer, saturating at zero.
    always_comb begin
        free_vtx = (fill_vtx >= VCAP) ? '0 : VCAP - fill_vtx;
        free_pix = (fill_pix >= PCAP) ? '0 : PCAP - fill_pix;
    end

    // Weighted scores.
    always_comb begin
        score_vtx = SCORE_W'(wgt_vtx) * SCORE_W'(free_vtx);
        score_pix = SCORE_W'(wgt_pix) * SCORE_W'(free_pix);
    end

    // Issue decision: lone ready kind first, otherwise the higher score, pixel on ties.
    always_comb begin
        issue = v_ready || p_ready;
        if (v_ready && !p_ready)
            pick = SHD_VTX;
        else if (p_ready && !v_ready)
            pick = SHD_PIX;
        else if (score_vtx > score_pix)
            pick = SHD_VTX;
        else
            pick = SHD_PIX;
    end

    // R5: a lone ready kind is the one picked (checked on every input change).
    always_comb begin
        if (v_ready && !p_ready)
            assert_lone_vertex_R5: assert (pick == SHD_VTX);
        if (p_ready && !v_ready)
            assert_lone_pixel_R5: assert (pick == SHD_PIX);
    end
endmodule

// File: rtl/shader_thread_arbiter.sv
// Top of the unified shader thread arbiter. Two in-order pools feed a
// weighted vertex/pixel balancer; the granted thread is popped from its pool
// at the edge that ends the grant cycle. Assumes the buffer fill inputs are
// synchronous to clk and that thread IDs are unique within a pool.
module shader_thread_arbiter #(
    parameter int DEPTH   = 8,
    parameter int ID_W    = 6,
    parameter int WGT_W   = 4,
    parameter int DEF_WGT = 8,
    parameter int FILL_W  = 7,
    parameter int VTX_CAP = 64,
    parameter int PIX_CAP = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vtx_push_valid,
    input  logic [ID_W-1:0]   vtx_push_id,
    output logic              vtx_stall,
    input  logic              pix_push_valid,
    input  logic [ID_W-1:0]   pix_push_id,
    output logic              pix_stall,
    input  logic              vtx_rdy_valid,
    input  logic [ID_W-1:0]   vtx_rdy_id,
    input  logic              pix_rdy_valid,
    input  logic [ID_W-1:0]   pix_rdy_id,
    input  logic [FILL_W-1:0] vtx_buf_fill,
    input  logic [FILL_W-1:0] pix_buf_fill,
    input  logic              wgt_wr_en,
    input  logic [WGT_W-1:0]  wgt_wr_vtx,
    input  logic [WGT_W-1:0]  wgt_wr_pix,
    output logic              grant_valid,
    output logic              grant_type,
    output logic [ID_W-1:0]   grant_id
);
    import sta_pkg::*;

    logic             v_head_ready, p_head_ready;
    logic [ID_W-1:0]  v_head_id, p_head_id;
    logic             v_pop, p_pop;
    logic [WGT_W-1:0] wgt_vtx, wgt_pix;
    logic             issue;
    shd_kind_e        pick;

    sta_thread_pool #(.DEPTH(DEPTH), .ID_W(ID_W)) u_vtx_pool (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_valid (vtx_push_valid),
        .push_id    (vtx_push_id),
        .stall      (vtx_stall),
        .rdy_valid  (vtx_rdy_valid),
        .rdy_id     (vtx_rdy_id),
        .pop        (v_pop),
        .head_ready (v_head_ready),
        .head_id    (v_head_id)
    );

    sta_thread_pool #(.DEPTH(DEPTH), .ID_W(ID_W)) u_pix_pool (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_valid (pix_push_valid),
        .push_id    (pix_push_id),
        .stall      (pix_stall),
        .rdy_valid  (pix_rdy_valid),
        .rdy_id     (pix_rdy_id),
        .pop        (p_pop),
        .head_ready (p_head_ready),
        .head_id    (p_head_id)
    );

    sta_weight_reg #(.WGT_W(WGT_W), .DEF_WGT(DEF_WGT)) u_weights (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wgt_wr_en),
        .wr_vtx  (wgt_wr_vtx),
        .wr_pix  (wgt_wr_pix),
        .wgt_vtx (wgt_vtx),
        .wgt_pix (wgt_pix)
    );

    sta_balance #(
        .WGT_W(WGT_W), .FILL_W(FILL_W), .VTX_CAP(VTX_CAP), .PIX_CAP(PIX_CAP)
    ) u_balance (
        .v_ready  (v_head_ready),
        .p_ready  (p_head_ready),
        .wgt_vtx  (wgt_vtx),
        .wgt_pix  (wgt_pix),
        .fill_vtx (vtx_buf_fill),
        .fill_pix (pix_buf_fill),
        .issue    (issue),
        .pick     (pick)
    );

    // Route the decision to the grant port and to the winning pool's pop.
    always_comb begin
        grant_valid = issue;
        grant_type  = (pick == SHD_PIX);
        grant_id    = (pick == SHD_PIX) ? p_head_id : v_head_id;
        v_pop       = issue && (pick == SHD_VTX);
        p_pop       = issue && (pick == SHD_PIX);
    end

    // R8: never more than one pool popped in a cycle.
    assert_single_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({v_pop, p_pop}));

    // R9: a ready head in either pool always produces a grant.
    assert_never_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (v_head_ready || p_head_ready) |-> grant_valid);

    // R3: a granted kind always has a ready oldest entry.
    assert_grant_from_ready_head_R3: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (grant_type ? p_head_ready : v_head_ready));

    // R10: the first cycle after reset shows empty pools and no grant.
    assert_reset_state_R10: assert property (@(posedge clk)
        !rst_n |=> (!grant_valid && !vtx_stall && !pix_stall));
endmodule

// File: tb/shader_thread_arbiter_tb_top.sv
`timescale 1ns/1ps
module shader_thread_arbiter_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       vtx_push_valid, pix_push_valid;
    logic [5:0] vtx_push_id, pix_push_id;
    logic       vtx_stall, pix_stall;
    logic       vtx_rdy_valid, pix_rdy_valid;
    logic [5:0] vtx_rdy_id, pix_rdy_id;
    logic [6:0] vtx_buf_fill, pix_buf_fill;
    logic       wgt_wr_en;
    logic [3:0] wgt_wr_vtx, wgt_wr_pix;
    logic       grant_valid, grant_type;
    logic [5:0] grant_id;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    shader_thread_arbiter dut_i (
        .clk(clk), .rst_n(rst_n),
        .vtx_push_valid(vtx_push_valid), .vtx_push_id(vtx_push_id), .vtx_stall(vtx_stall),
        .pix_push_valid(pix_push_valid), .pix_push_id(pix_push_id), .pix_stall(pix_stall),
        .vtx_rdy_valid(vtx_rdy_valid), .vtx_rdy_id(vtx_rdy_id),
        .pix_rdy_valid(pix_rdy_valid), .pix_rdy_id(pix_rdy_id),
        .vtx_buf_fill(vtx_buf_fill), .pix_buf_fill(pix_buf_fill),
        .wgt_wr_en(wgt_wr_en), .wgt_wr_vtx(wgt_wr_vtx), .wgt_wr_pix(wgt_wr_pix),
        .grant_valid(grant_valid), .grant_type(grant_type), .grant_id(grant_id)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expect a grant of the given kind and ID.
    task automatic expect_grant(input string req, input bit kind, input int id);
        chk(grant_valid && grant_type == kind && int'(grant_id) == id, req,
            {grant_valid, grant_type, grant_id}, {1'b1, kind, id[5:0]});
    endtask

    task automatic expect_idle(input string req);
        chk(!grant_valid, req, grant_valid, 0);
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic clr();
        vtx_push_valid = 0; pix_push_valid = 0;
        vtx_rdy_valid  = 0; pix_rdy_valid  = 0;
        wgt_wr_en      = 0;
    endtask

    // Push one thread of each kind, then mark both ready in the same cycle.
    task automatic load_pair(input int vid, input int pid);
        vtx_push_valid = 1; vtx_push_id = vid[5:0];
        pix_push_valid = 1; pix_push_id = pid[5:0];
        tick(); clr();
        vtx_rdy_valid = 1; vtx_rdy_id = vid[5:0];
        pix_rdy_valid = 1; pix_rdy_id = pid[5:0];
        tick(); clr();
    endtask

    task automatic t_reset();
        chk(!grant_valid, "R10", grant_valid, 0);
        chk(!vtx_stall && !pix_stall, "R10", {vtx_stall, pix_stall}, 0);
    endtask

    // Fill the vertex pool, overfill it, mark ready in reverse order, drain.
    task automatic t_order();
        for (int k = 0; k < 8; k++) begin
            vtx_push_valid = 1; vtx_push_id = 6'(k);
            tick();
        end
        clr();
        chk(vtx_stall, "R1", vtx_stall, 1);
        vtx_push_valid = 1; vtx_push_id = 6'd50;
        tick(); clr();
        chk(vtx_stall, "R1", vtx_stall, 1);
        for (int k = 7; k >= 1; k--) begin
            vtx_rdy_valid = 1; vtx_rdy_id = 6'(k);
            tick(); clr();
            expect_idle("R3");
        end
        vtx_rdy_valid = 1; vtx_rdy_id = 6'd0;
        tick(); clr();
        for (int k = 0; k < 8; k++) begin
            expect_grant("R2", 1'b0, k);
            tick();
        end
        expect_idle("R1");
        chk(!vtx_stall, "R1", vtx_stall, 0);
        // The dropped ID 50 must not appear even when strobed.
        vtx_rdy_valid = 1; vtx_rdy_id = 6'd50;
        tick(); clr();
        expect_idle("R1");
    endtask

    // Strobes for absent IDs or the wrong pool leave no trace.
    task automatic t_absent();
        pix_rdy_valid = 1; pix_rdy_id = 6'd33;
        tick(); clr();
        pix_push_valid = 1; pix_push_id = 6'd33;
        tick(); clr();
        expect_idle("R4");
        vtx_rdy_valid = 1; vtx_rdy_id = 6'd33;
        tick(); clr();
        expect_idle("R4");
        pix_rdy_valid = 1; pix_rdy_id = 6'd33;
        tick(); clr();
        expect_grant("R4", 1'b1, 33);
        tick();
        expect_idle("R8");
    endtask

    // Equal scores with default weights: pixel first, then vertex without a gap.
    task automatic t_tie();
        vtx_buf_fill = 0; pix_buf_fill = 0;
        load_pair(10, 20);
        expect_grant("R6", 1'b1, 20);
        tick();
        expect_grant("R9", 1'b0, 10);
        tick();
        expect_idle("R8");
    endtask

    // Vertex-favoured fills, then a weight write that must wait one cycle.
    task automatic t_weights();
        vtx_buf_fill = 10; pix_buf_fill = 40;   // 8*54 vs 8*24
        load_pair(11, 21);
        wgt_wr_en = 1; wgt_wr_vtx = 4'd1; wgt_wr_pix = 4'd8;
        #1;
        expect_grant("R7", 1'b0, 11);
        tick(); clr();
        expect_grant("R9", 1'b1, 21);
        tick();
        load_pair(12, 22);                      // 1*54 vs 8*24
        expect_grant("R7", 1'b1, 22);
        tick();
        expect_grant("R6", 1'b0, 12);
        tick();
        vtx_buf_fill = 63; pix_buf_fill = 70;   // 1*1 vs 8*0 (saturated)
        load_pair(13, 23);
        expect_grant("R6", 1'b0, 13);
        tick();
        expect_grant("R6", 1'b1, 23);
        tick();
        expect_idle("R8");
    endtask

    // A lone ready kind wins even with no free buffer space.
    task automatic t_lone();
        vtx_buf_fill = 64; pix_buf_fill = 0;
        vtx_push_valid = 1; vtx_push_id = 6'd5;
        tick(); clr();
        vtx_rdy_valid = 1; vtx_rdy_id = 6'd5;
        tick(); clr();
        expect_grant("R5", 1'b0, 5);
        tick();
        vtx_buf_fill = 0; pix_buf_fill = 64;
        pix_push_valid = 1; pix_push_id = 6'd6;
        tick(); clr();
        pix_rdy_valid = 1; pix_rdy_id = 6'd6;
        tick(); clr();
        expect_grant("R5", 1'b1, 6);
        tick();
        expect_idle("R5");
    endtask

    // A blocked vertex head lets pixel go even though vertex would score higher.
    task automatic t_block();
        wgt_wr_en = 1; wgt_wr_vtx = 4'd8; wgt_wr_pix = 4'd1;
        vtx_buf_fill = 10; pix_buf_fill = 40;
        tick(); clr();
        vtx_push_valid = 1; vtx_push_id = 6'd30;
        pix_push_valid = 1; pix_push_id = 6'd40;
        tick(); clr();
        vtx_push_valid = 1; vtx_push_id = 6'd31;
        tick(); clr();
        vtx_rdy_valid = 1; vtx_rdy_id = 6'd31;
        pix_rdy_valid = 1; pix_rdy_id = 6'd40;
        tick(); clr();
        expect_grant("R3", 1'b1, 40);
        tick();
        expect_idle("R3");
        vtx_rdy_valid = 1; vtx_rdy_id = 6'd30;
        tick(); clr();
        expect_grant("R2", 1'b0, 30);
        tick();
        expect_grant("R2", 1'b0, 31);
        tick();
        expect_idle("R8");
    endtask

    initial begin
        rst_n = 0;
        clr();
        vtx_push_id = 0; pix_push_id = 0; vtx_rdy_id = 0; pix_rdy_id = 0;
        vtx_buf_fill = 0; pix_buf_fill = 0; wgt_wr_vtx = 0; wgt_wr_pix = 0;
        repeat (3) tick();
        rst_n = 1;
        tick();
        t_reset();
        t_order();
        t_absent();
        t_tie();
        t_weights();
        t_lone();
        t_block();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule